// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block moves one byte at a time over a synchronous three-wire link made of a serial clock, a data output and a data input. It runs in one of two roles. As clock master it makes the serial clock itself, dividing the system clock by a fixed amount, and runs one burst of eight clock pulses for each byte the host loads. As clock slave it samples an external serial clock through a two-flop synchroniser and shifts on the edge polarity chosen by an edge-select input.

Bits leave and arrive least significant first. Incoming bits collect in a shift register. When the eighth active edge arrives, the assembled byte is copied into a separate receive buffer. A one-cycle receive interrupt marks that copy, and a one-cycle transmit interrupt marks the same word end. If the buffer was not read before the next copy, the new byte overwrites it and a sticky overrun flag is raised.

Top module: `sio_port`

## Requirements
- R1: After reset, sck_o and sdo_o are high, rx_data_o is 0, busy_o, tx_irq_o, rx_irq_o and rx_overrun_o are all 0.
- R2: In master mode (clk_mode_i=1), a load starts eight clock pulses on sck_o. Each pulse is low for HALF_DIV system cycles and high for HALF_DIV cycles. Between words sck_o rests high.
- R3: sdo_o carries tx_data_i bit 0 from the load onward and moves to the next bit right after each active edge. Bit k is presented before the (k+1)-th active edge. In master mode the rising edge of sck_o is the active edge.
- R4: sdi_i is sampled on each active edge, least significant bit first. After eight active edges, rx_data_o holds the eight sampled bits.
- R5: In master mode, tx_irq_o is high for exactly one system cycle: the cycle in which sck_o returns high after the eighth pulse. busy_o clears in that same cycle.
- R6: In slave mode (clk_mode_i=0), the active edge is the rising edge of sck_i when edge_sel_i=0 and the falling edge when edge_sel_i=1. tx_irq_o pulses for one cycle, three system clock edges after the eighth active transition of sck_i, and stays low after every other transition.
- R7: rx_irq_o pulses in the same cycle as tx_irq_o. rx_data_o changes only in a cycle where rx_irq_o is high.
- R8: In slave mode, transitions of the non-selected polarity neither sample sdi_i nor advance sdo_o.
- R9: If a word completes while the previous byte is still unread (no rx_read_i pulse since the last copy), rx_data_o is overwritten and rx_overrun_o is set. It stays set until reset. A read in between prevents this.
- R10: A tx_load_i pulse while busy_o is high is ignored. The running word's sdo_o bits are unchanged and no further word starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_mode_i | input | 1 | 1: block drives serial clock, 0: external clock |
| edge_sel_i | input | 1 | Slave mode active edge, 0 rising, 1 falling |
| tx_load_i | input | 1 | Load pulse for transmit byte |
| tx_data_i | input | 8 | Byte to transmit |
| rx_read_i | input | 1 | Host has read the receive buffer |
| sck_i | input | 1 | External serial clock |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Generated serial clock |
| sdo_o | output | 1 | Serial data out |
| busy_o | output | 1 | Word in progress |
| rx_data_o | output | 8 | Receive buffer |
| rx_overrun_o | output | 1 | Sticky overrun flag |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
In slave mode the bench changes sdi_i between the rising and the falling transition of sck_i. The byte that lands in the buffer therefore shows which edge the design used, and a swapped edge decode returns the other pattern. After every transition it samples the interrupts at cycle precision: an off-by-one synchroniser depth, or an interrupt tied to the wrong edge of the last bit, shows up as a pulse one cycle early or late, or on the trailing transition. In master mode it measures every low phase and checks that the interrupt coincides with the eighth rise, so a wrong divider or a ninth pulse is caught. It also loads a second byte mid-word, which must not corrupt sdo_o or start a second burst, and it runs back-to-back words with and without an intervening read to expose a missing or non-sticky overrun.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned SIO_WORD_W = 8;
  localparam int unsigned SIO_HALF_DIV = 4;
endpackage

// File: rtl/sio_sck_gen.sv
module sio_sck_gen #(
  parameter int unsigned HALF_DIV = sio_pkg::SIO_HALF_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_stb_o
);
  localparam int unsigned CNT_W = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sck_q;
  logic             wrap;

  assign wrap       = run_i && (cnt_q == CNT_LAST);
  assign rise_stb_o = wrap && !sck_q;
  assign sck_o      = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sio_edge_det.sv
module sio_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic fall_sel_i,
  output logic stb_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], sck_i};
  end

  // sync_q[1] is the synchronised level, sync_q[2] its previous value
  assign stb_o = fall_sel_i ? (!sync_q[1] && sync_q[2])
                            : (sync_q[1] && !sync_q[2]);
endmodule

// File: rtl/sio_core.sv
module sio_core #(
  parameter int unsigned WORD_W = sio_pkg::SIO_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_out_i,
  input  logic              act_stb_i,
  input  logic              sdi_i,
  input  logic              tx_load_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              rx_read_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              sdo_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_overrun_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o
);
  localparam int unsigned BC_W = $clog2(WORD_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(WORD_W - 1);

  logic [BC_W-1:0]   bit_cnt_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q, rx_buf_q;
  logic [WORD_W-1:0] rx_next;
  logic              run_q, full_q, ovr_q, tx_irq_q, rx_irq_q;
  logic              last_bit, do_load;

  assign rx_next  = {sdi_i, rx_sh_q[WORD_W-1:1]};
  assign last_bit = act_stb_i && (bit_cnt_q == BC_LAST);
  assign busy_o   = run_q || (bit_cnt_q != '0);
  assign do_load  = tx_load_i && !busy_o && !act_stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      tx_sh_q   <= '1;
      rx_sh_q   <= '0;
      run_q     <= 1'b0;
    end else if (act_stb_i) begin
      rx_sh_q   <= rx_next;
      tx_sh_q   <= {1'b1, tx_sh_q[WORD_W-1:1]};
      bit_cnt_q <= last_bit ? '0 : bit_cnt_q + 1'b1;
      if (last_bit) run_q <= 1'b0;
    end else if (do_load) begin
      tx_sh_q <= tx_data_i;
      run_q   <= mode_out_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q <= '0;
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
      tx_irq_q <= 1'b0;
      rx_irq_q <= 1'b0;
    end else begin
      tx_irq_q <= last_bit;
      rx_irq_q <= last_bit;
      if (last_bit) begin
        rx_buf_q <= rx_next;
        full_q   <= 1'b1;
        if (full_q && !rx_read_i) ovr_q <= 1'b1;
      end else if (rx_read_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign run_o        = run_q;
  assign sdo_o        = tx_sh_q[0];
  assign rx_data_o    = rx_buf_q;
  assign rx_overrun_o = ovr_q;
  assign tx_irq_o     = tx_irq_q;
  assign rx_irq_o     = rx_irq_q;
endmodule

// File: rtl/sio_port.sv
module sio_port #(
  parameter int unsigned WORD_W   = sio_pkg::SIO_WORD_W,
  parameter int unsigned HALF_DIV = sio_pkg::SIO_HALF_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_mode_i,
  input  logic              edge_sel_i,
  input  logic              tx_load_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              rx_read_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_overrun_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o
);
  logic run, gen_stb, ext_stb, act_stb;

  sio_sck_gen #(.HALF_DIV(HALF_DIV)) i_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .sck_o(sck_o), .rise_stb_o(gen_stb)
  );

  sio_edge_det i_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i),
    .fall_sel_i(edge_sel_i), .stb_o(ext_stb)
  );

  assign act_stb = clk_mode_i ? gen_stb : ext_stb;

  sio_core #(.WORD_W(WORD_W)) i_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_out_i(clk_mode_i),
    .act_stb_i(act_stb), .sdi_i(sdi_i), .tx_load_i(tx_load_i),
    .tx_data_i(tx_data_i), .rx_read_i(rx_read_i), .run_o(run),
    .busy_o(busy_o), .sdo_o(sdo_o), .rx_data_o(rx_data_o),
    .rx_overrun_o(rx_overrun_o), .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o)
  );
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int unsigned WORD_W = sio_pkg::SIO_WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sck_o,
  input logic              busy_o,
  input logic [WORD_W-1:0] rx_data_o,
  input logic              rx_overrun_o,
  input logic              tx_irq_o,
  input logic              rx_irq_o
);
  a_r5_tx_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);

  a_r7_irq_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o == rx_irq_o);

  a_r7_buf_on_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_irq_o |-> $stable(rx_data_o));

  a_r2_sck_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sck_o);

  a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overrun_o |=> rx_overrun_o);
endmodule

bind sio_port sio_port_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_o(sck_o), .busy_o(busy_o),
  .rx_data_o(rx_data_o), .rx_overrun_o(rx_overrun_o),
  .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o)
);

// File: tb/test_sio_port.sv
module test_sio_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_mode = 1'b1, edge_sel = 1'b0, tx_load = 1'b0, rx_read = 1'b0;
  logic sck_in = 1'b0, sdi = 1'b0;
  logic [7:0] tx_data = '0;
  logic sck_o, sdo, busy, ovr, tx_irq, rx_irq;
  logic [7:0] rx_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_port #(.WORD_W(8), .HALF_DIV(HALF)) i_sio_port (
    .clk_i(clk), .rst_ni(rst_n), .clk_mode_i(clk_mode), .edge_sel_i(edge_sel),
    .tx_load_i(tx_load), .tx_data_i(tx_data), .rx_read_i(rx_read),
    .sck_i(sck_in), .sdi_i(sdi), .sck_o(sck_o), .sdo_o(sdo), .busy_o(busy),
    .rx_data_o(rx_data), .rx_overrun_o(ovr), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reset_test();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sck", sck_o, 1); check("R1 sdo", sdo, 1);
    check("R1 rx_data", rx_data, 0); check("R1 busy", busy, 0);
    check("R1 irq", {tx_irq, rx_irq}, 0); check("R1 overrun", ovr, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_buf();
    rx_read = 1'b1; @(negedge clk); rx_read = 1'b0;
  endtask

  // master mode word; inject=1 pulses a second load mid-word (R10)
  task automatic out_word(input logic [7:0] tx, input logic [7:0] rx, input bit inject);
    int lowc;
    clk_mode = 1'b1;
    tx_data = tx; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    check("R2 busy after load", busy, 1);
    for (int k = 0; k < 8; k++) begin
      while (sck_o) @(negedge clk);
      check("R3 sdo bit", sdo, tx[k]);
      sdi = rx[k];
      lowc = 0;
      while (!sck_o) begin
        if (inject && k == 3 && lowc == 1) begin
          tx_data = ~tx; tx_load = 1'b1;
        end else tx_load = 1'b0;
        lowc++;
        @(negedge clk);
      end
      tx_load = 1'b0;
      check("R2 low phase", lowc, HALF);
      check("R5 tx_irq", tx_irq, (k == 7));
      check("R7 rx_irq", rx_irq, (k == 7));
    end
    check("R5 busy clear", busy, 0);
    check("R4 rx_data", rx_data, rx);
    repeat (3 * HALF) @(negedge clk);
    check("R10 no extra word sck", sck_o, 1);
    check("R10 no extra word busy", busy, 0);
  endtask

  task automatic toggle_chk(input logic exp_irq);
    sck_in = ~sck_in;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R6 irq early", tx_irq | rx_irq, 0);
    @(posedge clk); @(negedge clk);
    check("R6 tx_irq", tx_irq, exp_irq);
    check("R7 rx_irq", rx_irq, exp_irq);
  endtask

  // slave mode; sdi = ra[k] across rising, rb[k] across falling
  task automatic in_word(input logic fall, input logic [7:0] tx,
                         input logic [7:0] ra, input logic [7:0] rb);
    clk_mode = 1'b0; edge_sel = fall; sck_in = 1'b0;
    repeat (4) @(negedge clk);
    tx_data = tx; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check("R8 sdo bit", sdo, tx[k]);
      sdi = ra[k];
      toggle_chk(!fall && k == 7);
      sdi = rb[k];
      toggle_chk(fall && k == 7);
    end
    check(fall ? "R8 falling capture" : "R6 rising capture", rx_data, fall ? rb : ra);
  endtask

  initial begin
    reset_test();
    out_word(8'hA5, 8'h3C, 0);
    read_buf();
    out_word(8'h81, 8'hC6, 0);
    check("R9 no overrun after read", ovr, 0);
    out_word(8'h5A, 8'h17, 1);
    check("R9 overrun set", ovr, 1);
    check("R9 overwritten", rx_data, 8'h17);
    in_word(1'b0, 8'h96, 8'hB4, 8'h4B);
    in_word(1'b1, 8'h2D, 8'h0F, 8'hE1);
    check("R9 overrun sticky", ovr, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule